// File: doc/BRIEF.md
# Real-Time Counter Interrupt Flag Register

This block holds the three sticky event flags of a real-time counter working in clock or calendar mode: counter overflow, synchronization complete, and alarm-0 match. The counter logic feeds single-cycle event pulses. The synchronization logic feeds a busy level and a cause marker. Software sees the flags in one byte-wide register, which it reads through a combinational read port and clears by writing ones.

A three-bit interrupt-enable mask sits beside the flags. It has two register views. Writing ones through the set view turns mask bits on, and writing ones through the clear view turns them off. Both views read back the current mask, placed at the same bit positions as the flags. The single interrupt output is high while any flag and its enable bit are both one.

The synchronization-complete flag records the end of a busy period. It is suppressed when that period was started by an enable or software-reset command. A one-bit tag, captured while busy is high, tells the two cases apart.

Top module: `rtc_flag_reg`

## Requirements
- R1: After reset, every flag and every enable bit is zero, `irq` is low, and reads at all three offsets return 0x00.
- R2: A high `ovfEvt` sampled at a clock edge sets the overflow flag, bit 7 at offset 0x08, from that edge on.
- R3: A high `alarmEvt` sampled at a clock edge sets the alarm flag, bit 0 at offset 0x08, from that edge on.
- R4: The sync-ready flag (bit 6 at offset 0x08) is set at the first edge where `syncBusy` samples low after sampling high, provided the busy period was not tagged.
- R5: A busy period is tagged when `busyCause` is high in the cycle `syncBusy` first samples high, or in any later cycle of that period while `syncBusy` is still high. A tagged period ends without setting sync-ready.
- R6: Writing offset 0x08 clears each flag whose data bit is one. Flags whose data bit is zero keep their value, and flags hold their value in the absence of writes.
- R7: When a set event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: Bits 5 to 1 read as zero at every offset, and writing ones to them changes nothing.
- R9: Writing ones at offset 0x07 sets the matching enable bits (7, 6, 0), and writing ones at offset 0x06 clears them. Both offsets read the mask.
- R10: `irq` is high exactly when some flag and its enable bit are both one, and it falls only after a write.
- R11: Writes to any other offset change neither flags nor mask, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ovfEvt | input | 1 | Overflow event pulse |
| alarmEvt | input | 1 | Alarm-0 match pulse |
| syncBusy | input | 1 | Synchronization busy level |
| busyCause | input | 1 | Marks the busy period as caused by enable or software reset |
| addr | input | 8 | Register offset for read and write |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong flag or mask bit shows up at `rdData` in the cycle straight after the edge that stored it, whenever the bench reads that offset. Through `irq` it shows up in that same cycle when the matching enable bit is on. A tag captured wrongly stays hidden until busy falls. The sync-ready bit then appears where it should not, or is missing, at the edge of the fall. For this reason the bench checks the read port and `irq` in every cycle against a reference model and does not wait for the end of the run.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned DATA_W    = 8;
  // flag index 0: alarm-0, 1: sync-ready, 2: overflow
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{0, 6, 7};

  typedef struct packed {
    logic [NUM_FLAGS-1:0] flagSet;
    logic [NUM_FLAGS-1:0] flagClr;
    logic [NUM_FLAGS-1:0] enaSet;
    logic [NUM_FLAGS-1:0] enaClr;
  } flagStrobes_t;
endpackage

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
  import rtc_flag_pkg::*;
#(
  parameter logic [7:0] FLAG_OFS    = 8'h08,
  parameter logic [7:0] ENA_SET_OFS = 8'h07,
  parameter logic [7:0] ENA_CLR_OFS = 8'h06
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ovfEvt,
  input  logic              alarmEvt,
  input  logic              syncBusy,
  input  logic              busyCause,
  input  logic [7:0]        addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output flagStrobes_t      strb
);
  logic busyQ;
  logic tagQ;
  logic busyRise;
  logic busyFall;
  logic [NUM_FLAGS-1:0] wrBits;

  assign busyRise = syncBusy & ~busyQ;
  assign busyFall = busyQ & ~syncBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      tagQ  <= 1'b0;
    end else begin
      busyQ <= syncBusy;
      if (busyRise)
        tagQ <= busyCause;
      else if (syncBusy && busyCause)
        tagQ <= 1'b1;
    end
  end

  // gather the implemented data bits into flag-index order
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_pick
    assign wrBits[i] = wrData[FLAG_POS[i]];
  end

  always_comb begin
    strb.flagSet = {ovfEvt, busyFall & ~tagQ, alarmEvt};
    strb.flagClr = (wrEn && addr == FLAG_OFS)    ? wrBits : '0;
    strb.enaSet  = (wrEn && addr == ENA_SET_OFS) ? wrBits : '0;
    strb.enaClr  = (wrEn && addr == ENA_CLR_OFS) ? wrBits : '0;
  end
endmodule

// File: rtl/rtc_flag_dp.sv
module rtc_flag_dp
  import rtc_flag_pkg::*;
#(
  parameter logic [7:0] FLAG_OFS    = 8'h08,
  parameter logic [7:0] ENA_SET_OFS = 8'h07,
  parameter logic [7:0] ENA_CLR_OFS = 8'h06
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobes_t         strb,
  input  logic [7:0]           addr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq,
  output logic [NUM_FLAGS-1:0] flagVec,
  output logic [NUM_FLAGS-1:0] enaVec
);
  logic [DATA_W-1:0] flagByte;
  logic [DATA_W-1:0] enaByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagVec <= '0;
      enaVec  <= '0;
    end else begin
      // a set in the same cycle as a clear wins
      flagVec <= (flagVec & ~strb.flagClr) | strb.flagSet;
      enaVec  <= (enaVec & ~strb.enaClr) | strb.enaSet;
    end
  end

  always_comb begin
    flagByte = '0;
    enaByte  = '0;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      flagByte[FLAG_POS[i]] = flagVec[i];
      enaByte[FLAG_POS[i]]  = enaVec[i];
    end
    if (addr == FLAG_OFS)
      rdData = flagByte;
    else if (addr == ENA_SET_OFS || addr == ENA_CLR_OFS)
      rdData = enaByte;
    else
      rdData = '0;
  end

  assign irq = |(flagVec & enaVec);
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_flag_pkg::*;
#(
  parameter logic [7:0] FLAG_OFS    = 8'h08,
  parameter logic [7:0] ENA_SET_OFS = 8'h07,
  parameter logic [7:0] ENA_CLR_OFS = 8'h06
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ovfEvt,
  input  logic       alarmEvt,
  input  logic       syncBusy,
  input  logic       busyCause,
  input  logic [7:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq
);
  flagStrobes_t strb;
  logic [NUM_FLAGS-1:0] flagVec;
  logic [NUM_FLAGS-1:0] enaVec;

  rtc_flag_ctrl #(
    .FLAG_OFS(FLAG_OFS), .ENA_SET_OFS(ENA_SET_OFS), .ENA_CLR_OFS(ENA_CLR_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ovfEvt(ovfEvt), .alarmEvt(alarmEvt),
    .syncBusy(syncBusy), .busyCause(busyCause), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .strb(strb)
  );

  rtc_flag_dp #(
    .FLAG_OFS(FLAG_OFS), .ENA_SET_OFS(ENA_SET_OFS), .ENA_CLR_OFS(ENA_CLR_OFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .rdData(rdData), .irq(irq), .flagVec(flagVec), .enaVec(enaVec)
  );
endmodule

// File: rtl/rtc_flag_chk.sv
module rtc_flag_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ovfEvt,
  input logic       alarmEvt,
  input logic       wrEn,
  input logic [7:0] rdData,
  input logic       irq,
  input logic [2:0] flagVec
);
  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> flagVec[2]);

  // R3
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvt |=> flagVec[0]);

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((flagVec & $past(flagVec)) == $past(flagVec)));

  // R8
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5:1] == 5'd0);

  // R10
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn));
endmodule

bind rtc_flag_reg rtc_flag_chk u_chk (
  .clk(clk), .rstN(rstN), .ovfEvt(ovfEvt), .alarmEvt(alarmEvt),
  .wrEn(wrEn), .rdData(rdData), .irq(irq), .flagVec(flagVec)
);

// File: tb/rtc_flag_reg_test.sv
module rtc_flag_reg_test;
  localparam logic [7:0] FOFS = 8'h08;
  localparam logic [7:0] SOFS = 8'h07;
  localparam logic [7:0] COFS = 8'h06;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ovfEvt = 0, alarmEvt = 0, syncBusy = 0, busyCause = 0, wrEn = 0;
  logic [7:0] addr = 8'h00, wrData = 8'h00;
  logic [7:0] rdData;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state: index 0 alarm, 1 sync-ready, 2 overflow
  logic [2:0] mFlag = '0, mEna = '0;
  logic mBusy = 0, mTag = 0;

  always #2 clk = ~clk;

  rtc_flag_reg uut (
    .clk(clk), .rstN(rstN), .ovfEvt(ovfEvt), .alarmEvt(alarmEvt),
    .syncBusy(syncBusy), .busyCause(busyCause), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] toByte(logic [2:0] v);
    return {v[2], v[1], 5'b0, v[0]};
  endfunction

  function automatic logic [2:0] fromByte(logic [7:0] b);
    return {b[7], b[6], b[0]};
  endfunction

  function automatic logic [7:0] expRead(logic [7:0] a);
    if (a == FOFS) return toByte(mFlag);
    if (a == SOFS || a == COFS) return toByte(mEna);
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive one cycle, compare the read port and irq, then advance the model
  task automatic tick(string req, logic ov, logic al, logic bz, logic cs,
                      logic [7:0] a, logic we, logic [7:0] wd);
    logic [2:0] setv, bits;
    ovfEvt = ov; alarmEvt = al; syncBusy = bz; busyCause = cs;
    addr = a; wrEn = we; wrData = wd;
    #1;
    check(req, rdData, expRead(a));
    check("R10", {7'b0, irq}, {7'b0, |(mFlag & mEna)});
    @(posedge clk);
    bits = fromByte(wd);
    setv = {ov, mBusy & ~bz & ~mTag, al};
    mFlag = (mFlag & ~((we && a == FOFS) ? bits : 3'b0)) | setv;
    mEna  = (mEna & ~((we && a == COFS) ? bits : 3'b0)) |
            ((we && a == SOFS) ? bits : 3'b0);
    if (bz && !mBusy) mTag = cs;
    else if (bz && cs) mTag = 1'b1;
    mBusy = bz;
    @(negedge clk);
  endtask

  task automatic rd(string req, logic [7:0] a);
    tick(req, 0, 0, syncBusy, 0, a, 0, 8'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h0005eed1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1", FOFS); rd("R1", SOFS); rd("R1", COFS);
    // R2 overflow capture
    tick("R2", 1, 0, 0, 0, FOFS, 0, 0);
    rd("R2", FOFS);
    // R6 write zero keeps, write one clears
    tick("R6", 0, 0, 0, 0, FOFS, 1, 8'h00);
    rd("R6", FOFS);
    tick("R6", 0, 0, 0, 0, FOFS, 1, 8'h80);
    rd("R6", FOFS);
    // R3 alarm capture
    tick("R3", 0, 1, 0, 0, FOFS, 0, 0);
    rd("R3", FOFS);
    // R4 untagged busy period
    tick("R4", 0, 0, 1, 0, FOFS, 0, 0);
    tick("R4", 0, 0, 1, 0, FOFS, 0, 0);
    tick("R4", 0, 0, 0, 0, FOFS, 0, 0);
    rd("R4", FOFS);
    // R8 clear everything with all ones, unimplemented bits stay zero
    tick("R8", 0, 0, 0, 0, FOFS, 1, 8'hFF);
    rd("R8", FOFS);
    tick("R8", 0, 0, 0, 0, SOFS, 1, 8'h3E);
    rd("R8", SOFS);
    // R5 cause at start of busy
    tick("R5", 0, 0, 1, 1, FOFS, 0, 0);
    tick("R5", 0, 0, 1, 0, FOFS, 0, 0);
    tick("R5", 0, 0, 0, 0, FOFS, 0, 0);
    rd("R5", FOFS);
    // R5 cause in the middle of busy
    tick("R5", 0, 0, 1, 0, FOFS, 0, 0);
    tick("R5", 0, 0, 1, 1, FOFS, 0, 0);
    tick("R5", 0, 0, 0, 0, FOFS, 0, 0);
    rd("R5", FOFS);
    // R7 set beats clear
    tick("R7", 1, 1, 0, 0, FOFS, 1, 8'h81);
    rd("R7", FOFS);
    // R9 enable set and clear views
    tick("R9", 0, 0, 0, 0, SOFS, 1, 8'h81);
    rd("R9", COFS);
    rd("R10", FOFS);
    tick("R9", 0, 0, 0, 0, COFS, 1, 8'h01);
    rd("R9", SOFS);
    // R10 clearing the enabled flag drops irq
    tick("R10", 0, 0, 0, 0, FOFS, 1, 8'h80);
    rd("R10", FOFS);
    // R11 other offsets
    tick("R11", 1, 0, 0, 0, 8'h09, 1, 8'hFF);
    rd("R11", 8'h09);
    rd("R11", FOFS);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] v;
      string req;
      v = $urandom;
      case (v[2:0])
        3'd0, 3'd1, 3'd2: a = FOFS;
        3'd3:             a = SOFS;
        3'd4:             a = COFS;
        default:          a = {4'b0, v[6:3]};
      endcase
      req = (a == FOFS) ? "R6" : (a == SOFS || a == COFS) ? "R9" : "R11";
      tick(req, v[10:8] == 0, v[13:11] == 0, v[17:14] != 0 ? syncBusy : ~syncBusy,
           v[21:19] == 0, a, v[22] & v[23], v[31:24]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule